// File: doc/BRIEF.md
# Programmable Binary-Stage Interval Timer

This block is a synchronous model of a 24-stage binary divider whose output taps one of sixteen stages. A slow timing input is sampled by the system clock, and each detected high-to-low transition of it advances the stage chain. The chain can drop its lowest eight stages, so the block divides by 2 up to 2^24. The output can follow the chosen stage as a square wave, or it can emit a one-shot pulse of fixed length on each rising transition of that stage.

Two level controls force the output. One clears the chain and drives the output low. The other clears the chain, drives the output high and, once released, lets the first timing edge pull the output low, so that the interval starts from a known point. A hold control freezes the chain while the timing source keeps running. A fast test configuration splits the chain into three 8-stage sections, which all advance on the same edge.

Top module: `prog_stage_timer`

## Requirements
- R1: While `rst_n` is low and after it is released with all controls low, `count_q` is 0 and `dec_out` is 0.
- R2: With all controls low, each falling edge of `tin` raises `count_q` by one. A rising edge of `tin` leaves `count_q` unchanged.
- R3: With `skip8` low and `mono_en` low, `dec_out` equals `count_q[8+sel]`.
- R4: With `skip8` high (and not in test mode), each falling edge of `tin` adds 256 to `count_q`, `count_q[7:0]` does not change, and `dec_out` (with `mono_en` low) equals `count_q[8+sel]`, so it toggles every 2^sel edges.
- R5: While `clr_in` is high outside test mode, `count_q` is 0 and `dec_out` is 0. This holds even when `set_in` is high too.
- R6: While `set_in` is high and `clr_in` is low, `dec_out` is 1 and `count_q` is 0. After `set_in` falls, the first falling edge of `tin` drives `dec_out` to 0 without counting, and the second falling edge makes `count_q` equal to 1.
- R7: While `hold_in` is high, falling edges of `tin` leave `count_q` unchanged. Once `hold_in` is low again, the next falling edge counts.
- R8: When `skip8`, `set_in` and `clr_in` are all high, the block is in test mode. `dec_out` is 1, and the bit fields [7:0], [15:8] and [23:16] each advance by one, without carry between them, on every falling edge. After 255 edges `count_q` is 24'hFFFFFF. Dropping `set_in` and `clr_in` together and then `skip8` keeps this value, and one further falling edge gives 0.
- R9: With `mono_en` high, each rising transition of the selected stage drives `dec_out` high for exactly PULSE_LEN (default 5) system clocks. Otherwise `dec_out` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low system reset |
| tin | input | 1 | Timing input; its falling edges advance the chain |
| set_in | input | 1 | Forces the output high and clears the chain |
| clr_in | input | 1 | Forces the output low and clears the chain |
| hold_in | input | 1 | Freezes the chain |
| skip8 | input | 1 | Bypasses the lowest eight stages |
| sel | input | 4 | Stage-select code |
| mono_en | input | 1 | Selects one-shot output instead of square wave |
| count_q | output | 24 | Stage values, bit 0 least significant |
| dec_out | output | 1 | Decoded output |

## Verification
In test mode the set force and the clear force are both active in the same cycle. They must not cancel each other: the chain keeps counting in sections, and the output is held high. The bench raises both controls together with the bypass high, clocks 255 edges, and checks the section pattern part-way through and the all-ones value at the end. It then releases the set and clear controls in the same cycle and checks that no pending-set state was left behind: the very next edge after the bypass drops must roll the chain to zero, not be swallowed. Outside test mode the same overlap of set and clear is driven, and the clear force must win.

// File: rtl/pst_pkg.sv
package pst_pkg;
   // bundle of the asynchronous-style controls that pass through the synchroniser
   typedef struct packed {
      logic tin;
      logic set;
      logic clr;
      logic hold;
   } pst_ctl_t;

   localparam int PST_CTL_W = $bits(pst_ctl_t);
endpackage

// File: rtl/pst_sync.sv
module pst_sync #(
   parameter int W      = 4,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_depth
      $error("pst_sync: STAGES must be at least 2");
   end

   logic [W-1:0] pipe [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            pipe[s] <= '0;
         else if (s == 0)
            pipe[s] <= d;
         else
            pipe[s] <= pipe[(s == 0) ? 0 : s-1];
      end
   end

   assign q = pipe[STAGES-1];
endmodule

// File: rtl/pst_counter.sv
module pst_counter #(
   parameter int SECT_W = 8,
   parameter int N_SECT = 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     clr,
   input  logic                     adv,
   input  logic                     bypass,
   input  logic                     split,
   output logic [SECT_W*N_SECT-1:0] count_q
);
   localparam int N = SECT_W * N_SECT;

   if (N_SECT < 2) begin : g_bad_sect
      $error("pst_counter: N_SECT must be at least 2");
   end

   logic [N_SECT-1:0] cin;
   logic [N_SECT-2:0] cout;

   for (genvar g = 0; g < N_SECT; g++) begin : g_sect
      logic [SECT_W-1:0] sec_q;

      if (g == 0) begin : g_first
         // lowest section is skipped entirely in bypass
         assign cin[g] = adv & ~bypass;
      end else if (g == 1) begin : g_second
         assign cin[g] = (split | bypass) ? adv : cout[g-1];
      end else begin : g_rest
         assign cin[g] = split ? adv : cout[g-1];
      end

      if (g < N_SECT-1) begin : g_carry
         assign cout[g] = cin[g] & (&sec_q);
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            sec_q <= '0;
         else if (clr)
            sec_q <= '0;
         else if (cin[g])
            sec_q <= sec_q + 1'b1;
      end

      assign count_q[g*SECT_W +: SECT_W] = sec_q;
   end
endmodule

// File: rtl/pst_oneshot.sv
module pst_oneshot #(
   parameter int PULSE_LEN = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic lvl,
   output logic pulse
);
   localparam int CW = $clog2(PULSE_LEN + 1);

   if (PULSE_LEN < 1) begin : g_bad_len
      $error("pst_oneshot: PULSE_LEN must be at least 1");
   end

   logic          lvl_d;
   logic [CW-1:0] left_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_d  <= 1'b0;
         left_q <= '0;
      end else if (clr) begin
         lvl_d  <= 1'b0;
         left_q <= '0;
      end else begin
         lvl_d <= lvl;
         if (lvl && !lvl_d)
            left_q <= CW'(PULSE_LEN);
         else if (left_q != '0)
            left_q <= left_q - 1'b1;
      end
   end

   assign pulse = (left_q != '0);
endmodule

// File: rtl/prog_stage_timer.sv
module prog_stage_timer #(
   parameter int SECT_W      = 8,
   parameter int N_SECT      = 3,
   parameter int SYNC_STAGES = 2,
   parameter int PULSE_LEN   = 5,
   localparam int N          = SECT_W * N_SECT,
   localparam int TAPS       = N - SECT_W,
   localparam int SEL_W      = $clog2(TAPS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tin,
   input  logic             set_in,
   input  logic             clr_in,
   input  logic             hold_in,
   input  logic             skip8,
   input  logic [SEL_W-1:0] sel,
   input  logic             mono_en,
   output logic [N-1:0]     count_q,
   output logic             dec_out
);
   import pst_pkg::*;

   localparam int IDX_W = $clog2(N);

   if ((1 << SEL_W) != TAPS) begin : g_bad_taps
      $error("prog_stage_timer: selectable stage count must be a power of two");
   end

   pst_ctl_t raw_c, syn_c;
   assign raw_c = '{tin: tin, set: set_in, clr: clr_in, hold: hold_in};

   pst_sync #(.W(PST_CTL_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_c),
      .q     (syn_c)
   );

   logic tin_s, set_s, clr_s, hold_s;
   assign tin_s  = syn_c.tin;
   assign set_s  = syn_c.set;
   assign clr_s  = syn_c.clr;
   assign hold_s = syn_c.hold;

   logic tin_d;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tin_d <= 1'b0;
      else        tin_d <= tin_s;
   end

   logic fall, test_m, force_lo, set_only;
   assign fall     = tin_d & ~tin_s;
   assign test_m   = skip8 & set_s & clr_s;
   assign force_lo = clr_s & ~test_m;
   assign set_only = set_s & ~clr_s;

   // pending-set: swallows the first edge after set is released
   logic set_pend;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         set_pend <= 1'b0;
      else if (force_lo)
         set_pend <= 1'b0;
      else if (set_only)
         set_pend <= 1'b1;
      else if (fall && !hold_s)
         set_pend <= 1'b0;
   end

   logic adv, chain_clr;
   assign chain_clr = force_lo | set_only;
   assign adv       = fall & ~hold_s & ~set_pend & ~chain_clr;

   pst_counter #(.SECT_W(SECT_W), .N_SECT(N_SECT)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (chain_clr),
      .adv     (adv),
      .bypass  (skip8 & ~test_m),
      .split   (test_m),
      .count_q (count_q)
   );

   logic [IDX_W-1:0] tap_idx;
   logic             tap_bit;
   assign tap_idx = IDX_W'(SECT_W) + IDX_W'(sel);
   assign tap_bit = count_q[tap_idx];

   logic pulse;
   pst_oneshot #(.PULSE_LEN(PULSE_LEN)) u_mono (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (chain_clr | test_m),
      .lvl   (tap_bit),
      .pulse (pulse)
   );

   always_comb begin
      if (force_lo)
         dec_out = 1'b0;
      else if (test_m || set_only || set_pend)
         dec_out = 1'b1;
      else if (mono_en)
         dec_out = pulse;
      else
         dec_out = tap_bit;
   end
endmodule

// File: rtl/pst_chk.sv
module pst_chk #(
   parameter int N = 24
) (
   input logic         clk,
   input logic         rst_n,
   input logic         fall,
   input logic         set_s,
   input logic         clr_s,
   input logic         hold_s,
   input logic         set_pend,
   input logic         skip8,
   input logic [N-1:0] count_q,
   input logic         dec_out
);
   // R2
   step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fall && !hold_s && !set_s && !clr_s && !set_pend && !skip8)
      |=> count_q == $past(count_q) + 1'b1);

   // R4
   skip_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (skip8 && !set_s && !clr_s) |=> count_q[7:0] == $past(count_q[7:0]));

   // R5
   clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_s && !skip8) |=> count_q == '0);

   // R5
   clr_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_s && !(skip8 && set_s)) |-> !dec_out);

   // R6
   set_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (set_s && !clr_s) |-> dec_out);

   // R7
   hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_s && !set_s && !clr_s) |=> $stable(count_q));

   // R8
   test_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (skip8 && set_s && clr_s) |-> dec_out);
endmodule

bind prog_stage_timer pst_chk #(.N(N)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .fall     (fall),
   .set_s    (set_s),
   .clr_s    (clr_s),
   .hold_s   (hold_s),
   .set_pend (set_pend),
   .skip8    (skip8),
   .count_q  (count_q),
   .dec_out  (dec_out)
);

// File: tb/prog_stage_timer_test.sv
module prog_stage_timer_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tin = 1'b1;
   logic        set_in = 1'b0, clr_in = 1'b0, hold_in = 1'b0, skip8 = 1'b0;
   logic [3:0]  sel = 4'd0;
   logic        mono_en = 1'b0;
   logic [23:0] count_q;
   logic        dec_out;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   prog_stage_timer uut (
      .clk(clk), .rst_n(rst_n), .tin(tin), .set_in(set_in), .clr_in(clr_in),
      .hold_in(hold_in), .skip8(skip8), .sel(sel), .mono_en(mono_en),
      .count_q(count_q), .dec_out(dec_out)
   );

   typedef struct packed {
      logic        byp;
      logic [3:0]  k;
      logic [15:0] n;
      logic [23:0] exp_cnt;
      logic        exp_dec;
   } vec_t;

   localparam vec_t VECS [8] = '{
      '{1'b0, 4'd0, 16'd3,   24'h000003, 1'b0},
      '{1'b0, 4'd0, 16'd7,   24'h000007, 1'b0},
      '{1'b0, 4'd0, 16'd300, 24'h00012C, 1'b1},
      '{1'b1, 4'd0, 16'd1,   24'h000100, 1'b1},
      '{1'b1, 4'd0, 16'd2,   24'h000200, 1'b0},
      '{1'b1, 4'd1, 16'd3,   24'h000300, 1'b1},
      '{1'b1, 4'd2, 16'd5,   24'h000500, 1'b1},
      '{1'b1, 4'd3, 16'd5,   24'h000500, 1'b0}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic settle();
      repeat (4) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic edge_once();
      tin = 1'b0;
      repeat (4) @(posedge clk);
      tin = 1'b1;
      repeat (4) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic edges(input int n);
      for (int i = 0; i < n; i++) edge_once();
   endtask

   task automatic clear_chain();
      clr_in = 1'b1; settle();
      clr_in = 1'b0; settle();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [23:0] snap;
      int hi;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1 during reset
      chk("R1", {7'd0, dec_out, count_q}, 32'd0);
      rst_n = 1'b1;
      settle();
      chk("R1", {7'd0, dec_out, count_q}, 32'd0);

      // R3 R4 table
      for (int v = 0; v < 8; v++) begin
         clear_chain();
         skip8 = VECS[v].byp;
         sel   = VECS[v].k;
         settle();
         edges(int'(VECS[v].n));
         chk(VECS[v].byp ? "R4 count" : "R2 count", {8'd0, count_q}, {8'd0, VECS[v].exp_cnt});
         chk(VECS[v].byp ? "R4 dec" : "R3 dec", {31'd0, dec_out}, {31'd0, VECS[v].exp_dec});
      end
      skip8 = 1'b0; sel = 4'd0;

      // R2 rising edge has no effect
      clear_chain();
      edges(2);
      tin = 1'b0; repeat (6) @(posedge clk); @(negedge clk);
      snap = count_q;
      chk("R2 fall", {8'd0, snap}, 32'd3);
      tin = 1'b1; repeat (6) @(posedge clk); @(negedge clk);
      chk("R2 rise", {8'd0, count_q}, {8'd0, snap});

      // R7 hold
      hold_in = 1'b1; settle();
      edges(4);
      chk("R7 held", {8'd0, count_q}, 32'd3);
      hold_in = 1'b0; settle();
      edge_once();
      chk("R7 resume", {8'd0, count_q}, 32'd4);

      // R6 set sequence
      set_in = 1'b1; settle();
      chk("R6 set dec", {31'd0, dec_out}, 32'd1);
      chk("R6 set cnt", {8'd0, count_q}, 32'd0);
      set_in = 1'b0; settle();
      chk("R6 pending", {31'd0, dec_out}, 32'd1);
      edge_once();
      chk("R6 first dec", {31'd0, dec_out}, 32'd0);
      chk("R6 first cnt", {8'd0, count_q}, 32'd0);
      edge_once();
      chk("R6 second", {8'd0, count_q}, 32'd1);

      // R5 clear wins over set outside test mode
      edges(2);
      set_in = 1'b1; clr_in = 1'b1; settle();
      chk("R5 both dec", {31'd0, dec_out}, 32'd0);
      chk("R5 both cnt", {8'd0, count_q}, 32'd0);
      set_in = 1'b0; settle();
      edges(2);
      chk("R5 clr holds", {8'd0, count_q}, 32'd0);
      clr_in = 1'b0; settle();

      // R8 test mode
      edges(3);
      clear_chain();
      skip8 = 1'b1; set_in = 1'b1; clr_in = 1'b1; settle();
      chk("R8 dec", {31'd0, dec_out}, 32'd1);
      edges(10);
      chk("R8 sections", {8'd0, count_q}, 32'h000A0A0A);
      edges(245);
      chk("R8 all ones", {8'd0, count_q}, 32'h00FFFFFF);
      set_in = 1'b0; clr_in = 1'b0; settle();
      skip8 = 1'b0; settle();
      chk("R8 kept", {8'd0, count_q}, 32'h00FFFFFF);
      edge_once();
      chk("R8 ripple", {8'd0, count_q}, 32'd0);

      // R9 one-shot
      clear_chain();
      skip8 = 1'b1; sel = 4'd0; mono_en = 1'b1; settle();
      hi = 0;
      tin = 1'b0;
      for (int c = 0; c < 14; c++) begin
         @(negedge clk);
         if (c == 6) tin = 1'b1;
         if (dec_out) hi++;
      end
      chk("R9 width", hi, 32'd5);
      hi = 0;
      tin = 1'b0;
      for (int c = 0; c < 14; c++) begin
         @(negedge clk);
         if (c == 6) tin = 1'b1;
         if (dec_out) hi++;
      end
      chk("R9 falling stage", hi, 32'd0);
      chk("R9 count", {8'd0, count_q}, 32'h00000200);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule